// File: doc/BRIEF.md
# DMA Channel Cycle Controller

This block sequences the transfers of a single DMA channel. It holds two control words, a primary and an alternate. Each word carries a 3-bit cycle mode, a remaining-count field holding N-1, a burst exponent R, a lock-on-exit bit, and end pointers for the source and the destination. A host loads either word through a register write port. The controller reads the selected word, issues one transfer-start strobe per cycle to a datapath with the source and destination addresses of that transfer, and writes the updated word back to its descriptor store after every arbitration burst.

The cycle mode sets how the channel continues. A basic word needs a new request for every burst. An auto-request word keeps running after its first request. Ping-pong and scatter-gather words hand over to the other word when they complete. A completed word is marked stop so that it cannot run twice. A burst-only lock decides whether the alternate word accepts single requests or burst requests only. The lock is updated as alternate peripheral scatter-gather cycles start and finish. The host loads the alternate word in the scatter-gather modes; reading task lists from memory is not part of this block.

Top module: `dmach_cycle_ctrl`

## Requirements
- R1: After reset both control words hold mode 000, xfer_go and done are low, and cur_alt is 0, which selects the primary word.
- R2: While the selected word has mode 000 (stop), requests on req_single and req_burst are ignored and no transfer starts.
- R3: With mode 001 (basic), each burst starts only when a request is present in an idle cycle. Without a request the channel stays idle between bursts.
- R4: With mode 010 (auto-request), a single request runs every burst of the word. Consecutive bursts are separated by exactly one idle cycle.
- R5: A word whose count field holds N-1 makes exactly N transfers. Each transfer drives xfer_src = src_end - remaining and xfer_dst = dst_end - remaining, so the addresses step up by one and the last transfer uses the end pointers.
- R6: One arbitration runs at most 2^R consecutive transfers. The word is then written back with its reduced count, and the next burst continues from that count.
- R7: done is a one-cycle pulse in the cycle after the last transfer of a word. That word's mode is then 000, so later requests on it are ignored.
- R8: With mode 011 (ping-pong), completion switches cur_alt to the other word, and alternation continues until the selected word has mode 000. A word the host has rewritten to basic does not hand over when it completes.
- R9: Modes 100/101 (memory scatter-gather, primary/alternate) and 110/111 (peripheral scatter-gather, primary/alternate) switch to the other word on completion. The memory modes run without further requests, and the peripheral modes need a request for each burst.
- R10: While the burst-only lock is set, the alternate word accepts only req_burst and ignores req_single. The primary word accepts both request types.
- R11: When an alternate mode-111 burst starts with fewer than 2^R transfers left, the lock is cleared. When such a word completes with its lock-on-exit bit at 1, the lock is set. With that bit at 0 the lock is left unchanged.
- R12: A switch on completion into a self-running word (010, 100 or 101) continues without a new request. A switch into any other mode waits for a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_single | input | 1 | Single transfer request |
| req_burst | input | 1 | Burst transfer request |
| host_we | input | 1 | Host write of one control word |
| host_alt | input | 1 | Word written: 0 primary, 1 alternate |
| host_mode | input | 3 | Cycle mode to load |
| host_next_lock | input | 1 | Lock-on-exit bit to load |
| host_rpow | input | RP_W | Burst exponent R to load |
| host_remain | input | CNT_W | Remaining count N-1 to load |
| host_src_end | input | ADDR_W | Source end pointer to load |
| host_dst_end | input | ADDR_W | Destination end pointer to load |
| xfer_go | output | 1 | Transfer-start strobe, one per transfer |
| xfer_src | output | ADDR_W | Source address of the current transfer |
| xfer_dst | output | ADDR_W | Destination address of the current transfer |
| done | output | 1 | One-cycle pulse when a word completes |
| cur_alt | output | 1 | Word in use: 0 primary, 1 alternate |

## Verification
Some properties are checked on every cycle: a burst never runs longer than 2^R strobes, addresses inside a burst step up by one, done lasts one cycle and always follows a final strobe, a stopped word never starts, and a locked alternate word never starts from a single request alone. Other behaviour only the bench scenarios can show, because it depends on the history of a word across bursts and hand-overs. This covers the need for a fresh request in basic mode, auto-request continuation, the ping-pong and scatter-gather hand-overs, self-invalidation, and the way the lock is set and cleared over a sequence of alternate cycles.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
   typedef enum logic [2:0] {
      CM_STOP     = 3'b000,
      CM_BASIC    = 3'b001,
      CM_AUTO     = 3'b010,
      CM_PINGPONG = 3'b011,
      CM_MSG_PRI  = 3'b100,
      CM_MSG_ALT  = 3'b101,
      CM_PSG_PRI  = 3'b110,
      CM_PSG_ALT  = 3'b111
   } cyc_mode_e;

   // modes that insert their own requests after the first one
   function automatic logic mode_self_runs(logic [2:0] m);
      return (m == CM_AUTO) || (m == CM_MSG_PRI) || (m == CM_MSG_ALT);
   endfunction

   // modes that hand over to the other word on completion
   function automatic logic mode_swaps(logic [2:0] m);
      return m[2] || (m == CM_PINGPONG);
   endfunction
endpackage

// File: rtl/dmach_desc_store.sv
`timescale 1ns/1ps
module dmach_desc_store #(
   parameter int CNT_W  = 10,
   parameter int ADDR_W = 16,
   parameter int RP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_alt,
   input  logic [2:0]        host_mode,
   input  logic              host_nb,
   input  logic [RP_W-1:0]   host_rpow,
   input  logic [CNT_W-1:0]  host_rem,
   input  logic [ADDR_W-1:0] host_src,
   input  logic [ADDR_W-1:0] host_dst,
   input  logic              ctl_we,
   input  logic              ctl_alt,
   input  logic [2:0]        ctl_mode,
   input  logic [CNT_W-1:0]  ctl_rem,
   input  logic              rd_alt,
   output logic [2:0]        rd_mode,
   output logic              rd_nb,
   output logic [RP_W-1:0]   rd_rpow,
   output logic [CNT_W-1:0]  rd_rem,
   output logic [ADDR_W-1:0] rd_src,
   output logic [ADDR_W-1:0] rd_dst,
   output logic [2:0]        oth_mode
);
   localparam int N_WORDS = 2;

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      logic [2:0]        mode_q;
      logic              nb_q;
      logic [RP_W-1:0]   rpow_q;
      logic [CNT_W-1:0]  rem_q;
      logic [ADDR_W-1:0] src_q;
      logic [ADDR_W-1:0] dst_q;
      logic              host_hit;
      logic              ctl_hit;

      assign host_hit = host_we && (host_alt == 1'(g));
      assign ctl_hit  = ctl_we && (ctl_alt == 1'(g));

      // host writes take priority over controller write-back
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= '0;
            nb_q   <= 1'b0;
            rpow_q <= '0;
            rem_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
         end else if (host_hit) begin
            mode_q <= host_mode;
            nb_q   <= host_nb;
            rpow_q <= host_rpow;
            rem_q  <= host_rem;
            src_q  <= host_src;
            dst_q  <= host_dst;
         end else if (ctl_hit) begin
            mode_q <= ctl_mode;
            rem_q  <= ctl_rem;
         end
      end
   end

   assign rd_mode  = rd_alt ? g_word[1].mode_q : g_word[0].mode_q;
   assign rd_nb    = rd_alt ? g_word[1].nb_q   : g_word[0].nb_q;
   assign rd_rpow  = rd_alt ? g_word[1].rpow_q : g_word[0].rpow_q;
   assign rd_rem   = rd_alt ? g_word[1].rem_q  : g_word[0].rem_q;
   assign rd_src   = rd_alt ? g_word[1].src_q  : g_word[0].src_q;
   assign rd_dst   = rd_alt ? g_word[1].dst_q  : g_word[0].dst_q;
   assign oth_mode = rd_alt ? g_word[0].mode_q : g_word[1].mode_q;
endmodule

// File: rtl/dmach_addr_gen.sv
`timescale 1ns/1ps
module dmach_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 10
) (
   input  logic [ADDR_W-1:0] end_ptr,
   input  logic [CNT_W-1:0]  remain,
   output logic [ADDR_W-1:0] addr
);
   assign addr = end_ptr - ADDR_W'(remain);
endmodule

// File: rtl/dmach_seq.sv
`timescale 1ns/1ps
module dmach_seq
   import dmach_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int ADDR_W = 16,
   parameter int RP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_single,
   input  logic              req_burst,
   input  logic [2:0]        rd_mode,
   input  logic              rd_nb,
   input  logic [RP_W-1:0]   rd_rpow,
   input  logic [CNT_W-1:0]  rd_rem,
   input  logic [ADDR_W-1:0] rd_src,
   input  logic [ADDR_W-1:0] rd_dst,
   input  logic [2:0]        oth_mode,
   output logic              sel_alt,
   output logic              ctl_we,
   output logic [2:0]        ctl_mode,
   output logic [CNT_W-1:0]  ctl_rem,
   output logic              busy,
   output logic              done,
   output logic              lock_q,
   output logic              auto_q,
   output logic [RP_W-1:0]   w_rpow,
   output logic [CNT_W-1:0]  w_rem,
   output logic [ADDR_W-1:0] w_src,
   output logic [ADDR_W-1:0] w_dst
);
   logic [2:0]       w_mode;
   logic             w_nb;
   logic [CNT_W-1:0] bcnt;
   logic             lst_xfer, brst_end, req_ok, start, short_tail;

   always_comb begin
      lst_xfer   = busy && (w_rem == '0);
      brst_end   = busy && !lst_xfer && ((64'(bcnt) + 64'd1) == (64'd1 << w_rpow));
      req_ok     = req_burst || (req_single && !(sel_alt && lock_q));
      start      = !busy && (rd_mode != CM_STOP) && (auto_q || req_ok);
      short_tail = (64'(rd_rem) + 64'd1) < (64'd1 << rd_rpow);
      ctl_we     = lst_xfer || brst_end;
      ctl_mode   = lst_xfer ? 3'(CM_STOP) : w_mode;
      ctl_rem    = lst_xfer ? '0 : w_rem - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         sel_alt <= 1'b0;
         lock_q  <= 1'b0;
         auto_q  <= 1'b0;
         w_mode  <= '0;
         w_nb    <= 1'b0;
         w_rpow  <= '0;
         w_rem   <= '0;
         w_src   <= '0;
         w_dst   <= '0;
         bcnt    <= '0;
      end else begin
         done <= lst_xfer;
         if (start) begin
            busy   <= 1'b1;
            w_mode <= rd_mode;
            w_nb   <= rd_nb;
            w_rpow <= rd_rpow;
            w_rem  <= rd_rem;
            w_src  <= rd_src;
            w_dst  <= rd_dst;
            bcnt   <= '0;
            auto_q <= mode_self_runs(rd_mode);
            if (sel_alt && (rd_mode == CM_PSG_ALT) && short_tail)
               lock_q <= 1'b0;
         end else if (!busy && (rd_mode == CM_STOP)) begin
            auto_q <= 1'b0;
         end else if (lst_xfer) begin
            busy <= 1'b0;
            if (sel_alt && (w_mode == CM_PSG_ALT) && w_nb)
               lock_q <= 1'b1;
            if (mode_swaps(w_mode)) begin
               sel_alt <= ~sel_alt;
               auto_q  <= mode_self_runs(oth_mode);
            end else begin
               auto_q <= 1'b0;
            end
         end else if (brst_end) begin
            busy  <= 1'b0;
            w_rem <= w_rem - 1'b1;
         end else if (busy) begin
            w_rem <= w_rem - 1'b1;
            bcnt  <= bcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmach_cycle_ctrl.sv
`timescale 1ns/1ps
module dmach_cycle_ctrl
   import dmach_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int ADDR_W = 16,
   parameter int RP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_single,
   input  logic              req_burst,
   input  logic              host_we,
   input  logic              host_alt,
   input  logic [2:0]        host_mode,
   input  logic              host_next_lock,
   input  logic [RP_W-1:0]   host_rpow,
   input  logic [CNT_W-1:0]  host_remain,
   input  logic [ADDR_W-1:0] host_src_end,
   input  logic [ADDR_W-1:0] host_dst_end,
   output logic              xfer_go,
   output logic [ADDR_W-1:0] xfer_src,
   output logic [ADDR_W-1:0] xfer_dst,
   output logic              done,
   output logic              cur_alt
);
   localparam int N_PTR = 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (ADDR_W < CNT_W) begin : g_bad_addr
      $error("ADDR_W must be at least CNT_W");
   end
   if (RP_W < 1 || RP_W > 6) begin : g_bad_rpow
      $error("RP_W must lie in 1..6");
   end

   logic [2:0]        rd_mode, oth_mode, ctl_mode;
   logic              rd_nb, ctl_we, busy, lock_q, auto_q;
   logic [RP_W-1:0]   rd_rpow, w_rpow;
   logic [CNT_W-1:0]  rd_rem, ctl_rem, w_rem;
   logic [ADDR_W-1:0] rd_src, rd_dst, w_src, w_dst;
   logic [N_PTR-1:0][ADDR_W-1:0] end_ptrs, addrs;

   dmach_desc_store #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RP_W(RP_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_alt(host_alt), .host_mode(host_mode),
      .host_nb(host_next_lock), .host_rpow(host_rpow), .host_rem(host_remain),
      .host_src(host_src_end), .host_dst(host_dst_end),
      .ctl_we(ctl_we), .ctl_alt(cur_alt), .ctl_mode(ctl_mode), .ctl_rem(ctl_rem),
      .rd_alt(cur_alt), .rd_mode(rd_mode), .rd_nb(rd_nb), .rd_rpow(rd_rpow),
      .rd_rem(rd_rem), .rd_src(rd_src), .rd_dst(rd_dst), .oth_mode(oth_mode)
   );

   dmach_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RP_W(RP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_single(req_single), .req_burst(req_burst),
      .rd_mode(rd_mode), .rd_nb(rd_nb), .rd_rpow(rd_rpow), .rd_rem(rd_rem),
      .rd_src(rd_src), .rd_dst(rd_dst), .oth_mode(oth_mode),
      .sel_alt(cur_alt), .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_rem(ctl_rem),
      .busy(busy), .done(done), .lock_q(lock_q), .auto_q(auto_q),
      .w_rpow(w_rpow), .w_rem(w_rem), .w_src(w_src), .w_dst(w_dst)
   );

   assign end_ptrs = {w_dst, w_src};

   for (genvar g = 0; g < N_PTR; g++) begin : g_addr
      dmach_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ag (
         .end_ptr(end_ptrs[g]), .remain(w_rem), .addr(addrs[g])
      );
   end

   assign xfer_go  = busy;
   assign xfer_src = addrs[0];
   assign xfer_dst = addrs[1];
endmodule

// File: rtl/dmach_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module dmach_cycle_ctrl_chk #(
   parameter int ADDR_W = 16,
   parameter int RP_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_burst,
   input logic              xfer_go,
   input logic [ADDR_W-1:0] xfer_src,
   input logic [ADDR_W-1:0] xfer_dst,
   input logic              done,
   input logic              cur_alt,
   input logic              lock_q,
   input logic              auto_q,
   input logic [2:0]        cur_mode,
   input logic [RP_W-1:0]   w_rpow
);
   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= xfer_go ? run_q + 1 : '0;
   end

   a_r6_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |-> (64'(run_q) < (64'd1 << w_rpow)));

   a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && $past(xfer_go)) |-> (xfer_src == ADDR_W'($past(xfer_src) + 1'b1)));

   a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && $past(xfer_go)) |-> (xfer_dst == ADDR_W'($past(xfer_dst) + 1'b1)));

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!xfer_go && $past(xfer_go)));

   a_r2_stop_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_go && (cur_mode == 3'b000)) |=> !xfer_go);

   a_r10_lock_blocks_single: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_go && cur_alt && lock_q && !auto_q && !req_burst) |=> !xfer_go);
endmodule

bind dmach_cycle_ctrl dmach_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .RP_W(RP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_burst(req_burst),
   .xfer_go(xfer_go), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
   .done(done), .cur_alt(cur_alt), .lock_q(lock_q), .auto_q(auto_q),
   .cur_mode(rd_mode), .w_rpow(w_rpow)
);

// File: tb/dmach_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module dmach_cycle_ctrl_tb;
   localparam int CW = 10;
   localparam int AW = 16;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_single = 1'b0, req_burst = 1'b0;
   logic          host_we = 1'b0, host_alt = 1'b0, host_next_lock = 1'b0;
   logic [2:0]    host_mode = '0;
   logic [RW-1:0] host_rpow = '0;
   logic [CW-1:0] host_remain = '0;
   logic [AW-1:0] host_src_end = '0, host_dst_end = '0;
   logic          xfer_go, done, cur_alt;
   logic [AW-1:0] xfer_src, xfer_dst;

   int    n_chk = 0, n_fail = 0;
   bit    finished = 0;
   string tag = "R1";

   // reference model state
   int m_mode[2], m_nb[2], m_rp[2], m_rem[2], m_src[2], m_dst[2];
   bit m_busy, m_alt, m_auto, m_lock, m_done;
   int w_mode, w_nb, w_rp, w_rem, w_src, w_dst, m_bcnt;

   always #2 clk = ~clk;

   dmach_cycle_ctrl #(.CNT_W(CW), .ADDR_W(AW), .RP_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_single(req_single), .req_burst(req_burst),
      .host_we(host_we), .host_alt(host_alt), .host_mode(host_mode),
      .host_next_lock(host_next_lock), .host_rpow(host_rpow), .host_remain(host_remain),
      .host_src_end(host_src_end), .host_dst_end(host_dst_end),
      .xfer_go(xfer_go), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
      .done(done), .cur_alt(cur_alt)
   );

   function automatic bit self_runs(int m);
      return (m == 2) || (m == 4) || (m == 5);
   endfunction

   always @(posedge clk) begin : model
      bit nd;
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_mode[i] = 0; m_nb[i] = 0; m_rp[i] = 0; m_rem[i] = 0; m_src[i] = 0; m_dst[i] = 0;
         end
         m_busy = 0; m_alt = 0; m_auto = 0; m_lock = 0; m_done = 0;
         w_mode = 0; w_nb = 0; w_rp = 0; w_rem = 0; w_src = 0; w_dst = 0; m_bcnt = 0;
      end else begin
         nd = 0;
         if (m_busy) begin
            if (w_rem == 0) begin
               m_mode[m_alt] = 0;
               m_rem[m_alt] = 0;
               nd = 1;
               m_busy = 0;
               if (m_alt && w_mode == 7 && w_nb != 0) m_lock = 1;
               if (w_mode >= 3) begin
                  m_alt = !m_alt;
                  m_auto = self_runs(m_mode[m_alt]);
               end else m_auto = 0;
            end else if (m_bcnt + 1 == (1 << w_rp)) begin
               w_rem = w_rem - 1;
               m_rem[m_alt] = w_rem;
               m_busy = 0;
            end else begin
               w_rem = w_rem - 1;
               m_bcnt = m_bcnt + 1;
            end
         end else if (m_mode[m_alt] == 0) begin
            m_auto = 0;
         end else if (m_auto || req_burst || (req_single && !(m_alt && m_lock))) begin
            w_mode = m_mode[m_alt]; w_nb = m_nb[m_alt]; w_rp = m_rp[m_alt];
            w_rem = m_rem[m_alt]; w_src = m_src[m_alt]; w_dst = m_dst[m_alt];
            m_bcnt = 0;
            m_auto = self_runs(w_mode);
            if (m_alt && w_mode == 7 && (w_rem + 1) < (1 << w_rp)) m_lock = 0;
            m_busy = 1;
         end
         m_done = nd;
         if (host_we) begin
            m_mode[host_alt] = host_mode; m_nb[host_alt] = host_next_lock;
            m_rp[host_alt] = host_rpow; m_rem[host_alt] = host_remain;
            m_src[host_alt] = host_src_end; m_dst[host_alt] = host_dst_end;
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("xfer_go", int'(xfer_go), int'(m_busy));
         chk("done", int'(done), int'(m_done));
         chk("cur_alt", int'(cur_alt), int'(m_alt));
         if (m_busy) begin
            chk("xfer_src", int'(xfer_src), (w_src - w_rem) & 16'hFFFF);
            chk("xfer_dst", int'(xfer_dst), (w_dst - w_rem) & 16'hFFFF);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic load(bit alt, int mode, int nb, int rp, int n, int src, int dst);
      @(negedge clk);
      host_we = 1; host_alt = alt; host_mode = 3'(mode); host_next_lock = nb[0];
      host_rpow = RW'(rp); host_remain = CW'(n - 1);
      host_src_end = AW'(src); host_dst_end = AW'(dst);
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic pulse(bit burst);
      @(negedge clk);
      if (burst) req_burst = 1; else req_single = 1;
      @(negedge clk);
      req_burst = 0; req_single = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin : main
      // R1: reset state
      tag = "R1";
      do_reset();
      idle(3);
      // R2: stop word ignores requests
      tag = "R2";
      pulse(0); idle(4); pulse(1); idle(4);
      // R3,R6: basic, N=6, R=1 -> three bursts of two, each needs a request
      tag = "R3,R6";
      load(0, 1, 0, 1, 6, 16'h0040, 16'h0800);
      pulse(0); idle(8);
      pulse(1); idle(8);
      pulse(0); idle(8);
      // R7: word invalidated, further requests ignored
      tag = "R7";
      pulse(0); idle(6);
      // R4,R5: auto-request, N=7, R=2
      tag = "R4,R5";
      load(0, 2, 0, 2, 7, 16'h0100, 16'h0200);
      pulse(0); idle(20);
      // R8: ping-pong alternation, stop on invalid word
      tag = "R8";
      do_reset();
      load(0, 3, 0, 3, 3, 16'h0300, 16'h0400);
      load(1, 3, 0, 3, 2, 16'h0500, 16'h0600);
      @(negedge clk); req_single = 1;
      idle(20);
      req_single = 0;
      idle(4);
      // R8: host rewrites alternate to basic, alternation ends there
      load(0, 3, 0, 2, 2, 16'h0310, 16'h0410);
      load(1, 1, 0, 2, 2, 16'h0510, 16'h0610);
      pulse(0); idle(8);
      pulse(0); idle(8);
      pulse(0); idle(6);
      // R9,R12: memory scatter-gather runs on into self-running alternate
      tag = "R9,R12";
      do_reset();
      load(0, 4, 0, 1, 2, 16'h0700, 16'h0900);
      load(1, 5, 0, 1, 3, 16'h0A00, 16'h0B00);
      pulse(0); idle(20);
      // R9,R11: peripheral scatter-gather, alternate sets the lock on exit
      tag = "R9,R11";
      do_reset();
      load(0, 6, 0, 1, 2, 16'h1000, 16'h2000);
      load(1, 7, 1, 1, 4, 16'h3000, 16'h4000);
      pulse(0); idle(8);
      pulse(0); idle(8);
      pulse(0); idle(8);
      // R10: lock blocks single requests on the alternate word only
      tag = "R10";
      load(0, 6, 0, 0, 1, 16'h1100, 16'h2100);
      load(1, 7, 0, 2, 3, 16'h3100, 16'h4100);
      pulse(0); idle(6);
      pulse(0); idle(8);
      // R11: burst request starts a short tail, clearing the lock
      tag = "R11";
      pulse(1); idle(10);
      // R10,R11: with the lock clear, a single request starts the alternate
      tag = "R10,R11";
      load(0, 6, 0, 0, 1, 16'h1200, 16'h2200);
      load(1, 7, 0, 0, 2, 16'h3200, 16'h4200);
      pulse(0); idle(6);
      pulse(0); idle(6);
      pulse(0); idle(6);
      finished = 1;
      summary();
      $finish;
   end
endmodule